// File: doc/BRIEF.md
# Shared-Datapath Capacitor Integrator Bank

This block keeps the voltage of up to sixteen modelled capacitors and advances all of them once per solver step. One multiply stage, one rounding and saturation stage and one saturating adder are shared by every channel. A sequencer walks through the active channels one per clock. Each channel holds three settings: a gain equal to the step period divided by its capacitance, an initial voltage, and a selector that picks its current from a bank of sixteen current inputs. All values are signed Q16.16.

The block only steps when it is told to. A step strobe from outside starts a pass, and the whole current bank is captured at that edge. A one-cycle done pulse then marks the point where every active channel holds its new voltage. An init pulse loads every voltage from its initial-voltage setting and abandons any pass in progress. A combinational read port returns any channel's voltage.

The sequencer has two states. IDLE waits for a strobe. ISSUE sends one channel per cycle into the datapath. Its transitions are: IDLE to ISSUE on an accepted strobe (start); ISSUE to ISSUE on the next channel (advance); ISSUE to ISSUE on a strobe that arrives while the last channel is issued (restart); ISSUE to IDLE after the last channel when no strobe is present (finish); and any state to IDLE on init (abort).

Top module: `cap_bank_integrator`

## Requirements
- R1: After reset, all voltages read 0 and busy and done are low. Every gain and initial voltage is 0, and the selector of channel k is k.
- R2: A pass updates each active channel as V = V + round(I*G / 2^16), where I is the selected current and G is the channel gain. Rounding adds 2^15 to the full product and then shifts it right arithmetically by 16.
- R3: The rounded product is saturated to the signed 32-bit range (0x7FFFFFFF / 0x80000000). The sum with V is saturated to the same range.
- R4: The current bank is captured at the edge that accepts the strobe. Changes to cur_in after that edge do not affect the pass.
- R5: A selector code s (0..15) makes the channel use slot s of cur_in, which is bits [32s+31:32s]. Several channels may select the same slot.
- R6: Let the accepting edge be edge 0 and the number of active channels be N. Channels issue in ascending order. done is high for exactly one cycle, after edge N+2, and at that point all voltages of that pass are visible.
- R7: A strobe during ISSUE is ignored unless the last active channel is being issued on that edge. In that case the next pass starts at once, so strobes N cycles apart are all served.
- R8: The active count is sampled at the accepting edge. Channels at or above it keep their voltage. A count above 16 acts as 16, and a count of 0 makes the strobe ignored (no pass, no done).
- R9: init_pulse has priority over the strobe. It loads every voltage from its initial-voltage setting and cancels in-flight updates, so no done follows. In the next cycle done and busy are low.
- R10: Configuration writes use cfg_field 0 for gain, 1 for initial voltage and 2 for selector (low 4 bits). Gain and selector writes are used by later passes. A write to the initial voltage changes no voltage until the next init.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_field | input | 2 | Setting to write: 0 gain, 1 initial voltage, 2 selector |
| cfg_chan | input | 4 | Channel addressed by the write |
| cfg_wdata | input | 32 | Write data |
| init_pulse | input | 1 | Load all voltages from their initial settings |
| step_strobe | input | 1 | Starts an update pass |
| active_count | input | 5 | Number of channels to update, sampled with the strobe |
| cur_in | input | 512 | Sixteen Q16.16 currents, slot s at bits [32s+31:32s] |
| rd_chan | input | 4 | Channel to read |
| rd_volt | output | 32 | Voltage of rd_chan |
| busy | output | 1 | A pass is issuing or in flight |
| done | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The bench aims at the rounding edge of a half-LSB product, both positive and negative, and at saturation of both the product and the accumulated sum. A design that truncates, or lets a result wrap, would show a sign flip or an off-by-one voltage. It fires back-to-back strobes exactly N cycles apart, with N of 4 and of 1, and a strobe in the middle of a pass. A sequencer that drops a restart or takes a mid-pass strobe would then miss a done or produce an extra one. It also changes currents right after the strobe, uses counts of 0, 5 and 20, and issues an init in the middle of a pass. A design that samples currents late, updates skipped channels or lets an aborted pass finish would write wrong voltages or raise a stray done.

// File: rtl/cap_bank_pkg.sv
`timescale 1ns/1ps
package cap_bank_pkg;

    typedef enum logic {
        SQ_IDLE  = 1'b0,
        SQ_ISSUE = 1'b1
    } seq_state_t;

    typedef enum logic [1:0] {
        FLD_GAIN = 2'd0,
        FLD_INIT = 2'd1,
        FLD_SEL  = 2'd2
    } cfg_field_t;

endpackage

// File: rtl/cap_cfg_regs.sv
`timescale 1ns/1ps
module cap_cfg_regs
    import cap_bank_pkg::*;
#(
    parameter int NCH = 16,
    parameter int DW  = 32,
    localparam int CW = $clog2(NCH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [1:0]                    field,
    input  logic [CW-1:0]                 chan,
    input  logic [DW-1:0]                 wdata,
    output logic [NCH-1:0][DW-1:0]        gain_arr,
    output logic [NCH-1:0][DW-1:0]        init_arr,
    output logic [NCH-1:0][CW-1:0]        sel_arr
);

    for (genvar k = 0; k < NCH; k++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gain_arr[k] <= '0;
                init_arr[k] <= '0;
                sel_arr[k]  <= CW'(k);
            end else if (we && chan == CW'(k)) begin
                unique case (field)
                    FLD_GAIN: gain_arr[k] <= wdata;
                    FLD_INIT: init_arr[k] <= wdata;
                    FLD_SEL:  sel_arr[k]  <= wdata[CW-1:0];
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cap_seq.sv
`timescale 1ns/1ps
module cap_seq
    import cap_bank_pkg::*;
#(
    parameter int NCH = 16,
    localparam int CW = $clog2(NCH),
    localparam int NW = $clog2(NCH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          strobe,
    input  logic [NW-1:0] count,
    output logic          accept,
    output logic          issue_valid,
    output logic [CW-1:0] issue_ch,
    output logic          issue_last
);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] ch_q, ch_d, lim_q, lim_d;
    logic [NW-1:0] cnt_eff;

    always_comb begin
        cnt_eff = (count > NW'(NCH)) ? NW'(NCH) : count;
        accept  = !init && strobe && (cnt_eff != '0) &&
                  (state_q == SQ_IDLE || (state_q == SQ_ISSUE && ch_q == lim_q));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        ch_d    = ch_q;
        lim_d   = lim_q;
        if (init) begin
            state_d = SQ_IDLE;                       // abort
            ch_d    = '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (accept) begin           // start
                    state_d = SQ_ISSUE;
                    ch_d    = '0;
                    lim_d   = CW'(cnt_eff - NW'(1));
                end
                SQ_ISSUE: begin
                    if (ch_q != lim_q) begin         // advance
                        ch_d = ch_q + CW'(1);
                    end else if (accept) begin       // restart
                        ch_d  = '0;
                        lim_d = CW'(cnt_eff - NW'(1));
                    end else begin                   // finish
                        state_d = SQ_IDLE;
                        ch_d    = '0;
                    end
                end
                default: state_d = SQ_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            ch_q    <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
            lim_q   <= lim_d;
        end
    end

    // outputs
    always_comb begin
        issue_valid = (state_q == SQ_ISSUE);
        issue_ch    = ch_q;
        issue_last  = (state_q == SQ_ISSUE) && (ch_q == lim_q);
    end

    // R7: a strobe in the middle of a pass does not disturb the walk
    a_r7_mid_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_ISSUE && ch_q != lim_q && strobe && !init)
        |=> (state_q == SQ_ISSUE && ch_q == $past(ch_q) + CW'(1)));

    // R9: init always returns the sequencer to IDLE
    a_r9_init_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (state_q == SQ_IDLE));

endmodule

// File: rtl/cap_mac_pipe.sv
`timescale 1ns/1ps
module cap_mac_pipe #(
    parameter int NCH  = 16,
    parameter int DW   = 32,
    parameter int FRAC = 16,
    localparam int CW  = $clog2(NCH),
    localparam int PW  = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          in_valid,
    input  logic [CW-1:0] in_ch,
    input  logic          in_last,
    input  logic [DW-1:0] in_cur,
    input  logic [DW-1:0] in_gain,
    output logic          out_valid,
    output logic [CW-1:0] out_ch,
    output logic          out_last,
    output logic [DW-1:0] out_inc,
    output logic          busy
);

    localparam logic signed [PW:0]   HALF  = (PW + 1)'(1) << (FRAC - 1);
    localparam logic        [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic        [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};

    logic                 s1_valid, s1_last;
    logic [CW-1:0]        s1_ch;
    logic signed [PW-1:0] s1_prod;
    logic signed [PW:0]   rnd, shr;
    logic [PW-DW+1:0]     hi;
    logic [DW-1:0]        scaled;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            s1_valid <= 1'b0;
            s1_last  <= 1'b0;
            s1_ch    <= '0;
            s1_prod  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_last  <= in_last;
            s1_ch    <= in_ch;
            s1_prod  <= $signed(in_cur) * $signed(in_gain);
        end
    end

    always_comb begin
        rnd = $signed({s1_prod[PW-1], s1_prod}) + HALF;
        shr = rnd >>> FRAC;
        hi  = shr[PW:DW-1];
        if (&hi || ~|hi) scaled = shr[DW-1:0];
        else             scaled = shr[PW] ? S_MIN : S_MAX;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_ch    <= '0;
            out_inc   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_last  <= s1_last;
            out_ch    <= s1_ch;
            out_inc   <= scaled;
        end
    end

    assign busy = s1_valid | out_valid;

    // R6: every result leaving the datapath entered it two cycles earlier
    a_r6_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

endmodule

// File: rtl/cap_bank_integrator.sv
`timescale 1ns/1ps
module cap_bank_integrator #(
    parameter int NCH  = 16,
    parameter int DW   = 32,
    parameter int FRAC = 16,
    localparam int CW  = $clog2(NCH),
    localparam int NW  = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_field,
    input  logic [CW-1:0]     cfg_chan,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic              init_pulse,
    input  logic              step_strobe,
    input  logic [NW-1:0]     active_count,
    input  logic [NCH*DW-1:0] cur_in,
    input  logic [CW-1:0]     rd_chan,
    output logic [DW-1:0]     rd_volt,
    output logic              busy,
    output logic              done
);

    logic [NCH-1:0][DW-1:0] gain_arr, init_arr, cur_snap, v_q;
    logic [NCH-1:0][CW-1:0] sel_arr;
    logic                   accept, iss_valid, iss_last;
    logic [CW-1:0]          iss_ch, wb_ch;
    logic                   wb_valid, wb_last, pipe_busy;
    logic [DW-1:0]          wb_inc, iss_cur, iss_gain, wb_sum;
    logic signed [DW:0]     wide_sum;

    cap_cfg_regs #(.NCH(NCH), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .field(cfg_field),
        .chan(cfg_chan), .wdata(cfg_wdata),
        .gain_arr(gain_arr), .init_arr(init_arr), .sel_arr(sel_arr)
    );

    cap_seq #(.NCH(NCH)) u_seq (
        .clk(clk), .rst_n(rst_n), .init(init_pulse), .strobe(step_strobe),
        .count(active_count), .accept(accept), .issue_valid(iss_valid),
        .issue_ch(iss_ch), .issue_last(iss_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      cur_snap <= '0;
        else if (accept) cur_snap <= cur_in;
    end

    always_comb begin
        iss_cur  = cur_snap[sel_arr[iss_ch]];
        iss_gain = gain_arr[iss_ch];
    end

    cap_mac_pipe #(.NCH(NCH), .DW(DW), .FRAC(FRAC)) u_mac (
        .clk(clk), .rst_n(rst_n), .flush(init_pulse),
        .in_valid(iss_valid), .in_ch(iss_ch), .in_last(iss_last),
        .in_cur(iss_cur), .in_gain(iss_gain),
        .out_valid(wb_valid), .out_ch(wb_ch), .out_last(wb_last),
        .out_inc(wb_inc), .busy(pipe_busy)
    );

    // saturating accumulate on the addressed channel
    always_comb begin
        wide_sum = $signed({v_q[wb_ch][DW-1], v_q[wb_ch]}) + $signed({wb_inc[DW-1], wb_inc});
        if (wide_sum[DW] == wide_sum[DW-1]) wb_sum = wide_sum[DW-1:0];
        else wb_sum = wide_sum[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q  <= '0;
            done <= 1'b0;
        end else begin
            if (init_pulse)    v_q <= init_arr;
            else if (wb_valid) v_q[wb_ch] <= wb_sum;
            done <= !init_pulse && wb_valid && wb_last;
        end
    end

    assign rd_volt = v_q[rd_chan];
    assign busy    = iss_valid | pipe_busy;

    // R8: a channel's voltage moves only on its own write-back or on init
    for (genvar k = 0; k < NCH; k++) begin : g_hold
        a_r8_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!init_pulse && !(wb_valid && wb_ch == CW'(k))) |=> $stable(v_q[k]));
    end

    // R9: init clears done and empties the pipeline
    a_r9_init_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        init_pulse |=> (!done && !busy));

endmodule

// File: tb/cap_bank_integrator_bench.sv
`timescale 1ns/1ps
module cap_bank_integrator_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_field = '0;
    logic [3:0]   cfg_chan = '0;
    logic [31:0]  cfg_wdata = '0;
    logic         init_pulse = 1'b0;
    logic         step_strobe = 1'b0;
    logic [4:0]   active_count = '0;
    logic [511:0] cur_in;
    logic [3:0]   rd_chan = '0;
    logic [31:0]  rd_volt;
    logic         busy, done;

    always #2.5 clk = ~clk;   // 200 MHz

    cap_bank_integrator u_cap_bank_integrator (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
        .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata), .init_pulse(init_pulse),
        .step_strobe(step_strobe), .active_count(active_count), .cur_in(cur_in),
        .rd_chan(rd_chan), .rd_volt(rd_volt), .busy(busy), .done(done)
    );

    // reference model
    logic [31:0] cur_m  [16];
    logic [31:0] gain_m [16];
    logic [31:0] init_m [16];
    logic [3:0]  sel_m  [16];
    logic [31:0] v_m    [16];

    always_comb for (int k = 0; k < 16; k++) cur_in[k*32 +: 32] = cur_m[k];

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard queues: kind 0 = pass end, kind 1 = idle snapshot
    int           q_kind[$];
    int           q_due[$];
    logic [511:0] q_vals[$];
    string        q_tag[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sat64(input longint x);
        if (x > 64'sd2147483647)  return 32'h7fffffff;
        if (x < -64'sd2147483648) return 32'h80000000;
        return x[31:0];
    endfunction

    function automatic logic [31:0] m_scale(input logic [31:0] i, input logic [31:0] g);
        longint p;
        p = longint'($signed(i)) * longint'($signed(g));
        p = (p + 64'sd32768) >>> 16;
        return sat64(p);
    endfunction

    function automatic logic [31:0] m_add(input logic [31:0] a, input logic [31:0] b);
        return sat64(longint'($signed(a)) + longint'($signed(b)));
    endfunction

    function automatic logic [511:0] pack_v();
        logic [511:0] r;
        for (int k = 0; k < 16; k++) r[k*32 +: 32] = v_m[k];
        return r;
    endfunction

    task automatic push(input int kind, input int due, input string tag);
        q_kind.push_back(kind);
        q_due.push_back(due);
        q_vals.push_back(pack_v());
        q_tag.push_back(tag);
    endtask

    task automatic pop();
        void'(q_kind.pop_front());
        void'(q_due.pop_front());
        void'(q_vals.pop_front());
        void'(q_tag.pop_front());
    endtask

    task automatic read_compare(input logic [511:0] vals, input string tag);
        for (int ch = 0; ch < 16; ch++) begin
            rd_chan = 4'(ch);
            #0.1;
            check(rd_volt === vals[ch*32 +: 32], $sformatf("%s ch%0d", tag, ch), rd_volt, vals[ch*32 +: 32]);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (q_kind.size() > 0 && q_kind[0] == 1) begin
                check(done == 1'b0, {q_tag[0], " done low"}, 32'(done), 32'd0);
                read_compare(q_vals[0], q_tag[0]);
                pop();
            end else if (done) begin
                if (q_kind.size() == 0) begin
                    check(1'b0, "R6/R7/R8/R9 unexpected done", 32'd1, 32'd0);
                end else begin
                    check(cyc == q_due[0], {q_tag[0], " R6 done timing"}, 32'(cyc), 32'(q_due[0]));
                    read_compare(q_vals[0], q_tag[0]);
                    pop();
                end
            end else if (q_kind.size() > 0 && cyc > q_due[0]) begin
                check(1'b0, {q_tag[0], " R6 missing done"}, 32'(cyc), 32'(q_due[0]));
                pop();
            end
        end
    end

    // driver tasks (called at a negedge)
    task automatic cfg_write(input logic [1:0] f, input int ch, input logic [31:0] d);
        cfg_we = 1'b1; cfg_field = f; cfg_chan = 4'(ch); cfg_wdata = d;
        if (f == 2'd0) gain_m[ch] = d;
        if (f == 2'd1) init_m[ch] = d;
        if (f == 2'd2) sel_m[ch]  = d[3:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fire(input int cnt, input string tag);
        int ce;
        ce = (cnt > 16) ? 16 : cnt;
        active_count = 5'(cnt);
        step_strobe = 1'b1;
        for (int k = 0; k < ce; k++) v_m[k] = m_add(v_m[k], m_scale(cur_m[sel_m[k]], gain_m[k]));
        push(0, cyc + 1 + ce + 2, tag);
        @(negedge clk);
        step_strobe = 1'b0;
    endtask

    task automatic raw_strobe(input int cnt);
        active_count = 5'(cnt);
        step_strobe = 1'b1;
        @(negedge clk);
        step_strobe = 1'b0;
    endtask

    task automatic drain();
        while (q_kind.size() > 0 || busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_init(input string tag);
        init_pulse = 1'b1;
        @(negedge clk);
        init_pulse = 1'b0;
        check(done == 1'b0, {tag, " done cleared"}, 32'(done), 32'd0);
        check(busy == 1'b0, {tag, " busy cleared"}, 32'(busy), 32'd0);
        for (int k = 0; k < 16; k++) v_m[k] = init_m[k];
    endtask

    initial begin
        for (int k = 0; k < 16; k++) begin
            cur_m[k] = '0; gain_m[k] = '0; init_m[k] = '0; sel_m[k] = 4'(k); v_m[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", 32'(busy), 32'd0);
        check(done == 1'b0, "R1 done", 32'(done), 32'd0);
        push(1, 0, "R1 reset voltages");
        drain();

        // R1 identity selectors, R2 basic update, R10 gain writes used
        for (int k = 0; k < 16; k++) begin
            cfg_write(2'd0, k, 32'h0000_4000 * 32'(k + 1));
            cur_m[k] = 32'((k - 7) * 98304);
        end
        fire(16, "R1/R2/R10 identity pass");
        drain();

        // R5 permuted and shared selectors, R4 capture at strobe
        for (int k = 0; k < 16; k++) cfg_write(2'd2, k, 32'((k * 5 + 3) % 16));
        cfg_write(2'd2, 9, 32'd13);
        for (int k = 0; k < 16; k++) cur_m[k] = 32'(k * 7001 - 40000);
        fire(16, "R5 selector pass");
        for (int k = 0; k < 16; k++) cur_m[k] = 32'h1234_0000;   // R4: must not be seen
        drain();
        fire(16, "R4 late-change pass");
        drain();

        // R2 rounding and R3 saturation
        for (int k = 0; k < 5; k++) cfg_write(2'd2, k, 32'(k));
        cfg_write(2'd0, 0, 32'd1); cfg_write(2'd0, 1, 32'd1); cfg_write(2'd0, 2, 32'd1);
        cfg_write(2'd0, 3, 32'h7fff_ffff); cfg_write(2'd0, 4, 32'h7fff_ffff);
        cur_m[0] = 32'h0000_8000; cur_m[1] = 32'hffff_8000; cur_m[2] = 32'h0000_7fff;
        cur_m[3] = 32'h7fff_ffff; cur_m[4] = 32'h8000_0000;
        fire(16, "R2/R3 rounding pass");
        drain();
        fire(16, "R3 sum saturation pass");
        drain();

        // R8 partial count, clamp, zero count
        for (int k = 0; k < 16; k++) cur_m[k] = 32'(k * 3000 + 500);
        fire(5, "R8 count five");
        drain();
        fire(20, "R8 count clamp");
        drain();
        raw_strobe(0);
        repeat (4) begin
            check(busy == 1'b0, "R8 zero count busy", 32'(busy), 32'd0);
            @(negedge clk);
        end
        push(1, 0, "R8 zero count voltages");
        drain();

        // R7 back-to-back restarts, R6 timing
        fire(4, "R7 back-to-back A");
        repeat (3) @(negedge clk);
        fire(4, "R7 back-to-back B");
        drain();
        fire(1, "R7 single-channel A");
        fire(1, "R7 single-channel B");
        drain();

        // R7 mid-pass strobe ignored
        fire(6, "R7 mid-pass");
        raw_strobe(6);
        drain();

        // R10 initial-voltage write has no effect before init
        for (int k = 0; k < 16; k++) cfg_write(2'd1, k, 32'(k * 65536 - 196608));
        fire(16, "R10 no init effect");
        drain();

        // R9 init when idle, then init in the middle of a pass
        do_init("R9 idle init");
        push(1, 0, "R9 idle init voltages");
        drain();
        for (int k = 0; k < 16; k++) cfg_write(2'd1, k, 32'(k * 1000 + 7));
        raw_strobe(16);
        repeat (4) @(negedge clk);
        step_strobe = 1'b1;   // R9: init wins over a simultaneous strobe
        active_count = 5'd16;
        do_init("R9 mid-pass init");
        step_strobe = 1'b0;
        repeat (25) @(negedge clk);
        push(1, 0, "R9 mid-pass init voltages");
        drain();

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule